// File: doc/BRIEF.md
# Triangular Dithered Switching-Period Generator

This block divides a system clock of roughly 7 MHz to produce the start of each switching period for a DC/DC controller. The nominal division is 16 clocks for about 444 kHz or 8 clocks for about 888 kHz. With dithering switched on, each period is stretched or shortened along a triangular profile that stays within one eighth (12.5 %) of nominal. This spreads the emitted spectrum while the average period stays exactly at nominal.

Period lengths are held in fixed point with four fractional bits. A fractional remainder carries from one period to the next, so the whole-clock counts add up exactly to the ideal triangle. One triangle sweep lasts 25 periods at the slow setting and 50 at the fast setting. Both take 400 clocks, a modulation rate of about 17.76 kHz. The rate setting is only taken up at the start of a sweep. An optional hopping mode toggles between the two settings on every sweep boundary.

Top module: `dfs_dither_clk`

## Requirements
- R1: While `rst_n` is low, `tick` is 0 and `period_clks` is 0. On the first rising clock edge with `rst_n` high, a period starts: `tick` is 1 in the following cycle.
- R2: `tick` is a one-cycle pulse. The number of clocks from one `tick` to the next equals the `period_clks` value shown with the first of the two.
- R3: With `dith_en` low at a period start, that period lasts exactly 16 clocks for the slow setting and 8 clocks for the fast setting.
- R4: With `dith_en` high, every period lies within nominal ±1/8: 14 to 18 clocks slow, 7 to 9 clocks fast.
- R5: For phase index k (0 at the sweep start) in a sweep of N periods with nominal divide M, the fixed-point length in sixteenths of a clock is 16·M + trunc(2·M·t/N). The division rounds toward zero, and t is 4k for 4k ≤ N, 2N − 4k for 4k ≤ 3N, and 4k − 4N otherwise. N is 25 slow and 50 fast.
- R6: The clocks in a period are floor((r + L)/16), where L is the fixed-point length and r is the carried remainder. The new remainder is (r + L) mod 16. A full sweep with dithering held on therefore totals exactly N·M = 400 clocks.
- R7: `fast_sel` (0 = slow, 1 = fast) is sampled only at a period start whose phase index is 0. A change made mid-sweep does not affect the rest of that sweep.
- R8: With `hop_en` high, the setting used at each phase-0 period start is the opposite of the previous setting, and `fast_sel` is ignored.
- R9: A period started with `dith_en` low resets the phase index to 0 and clears the remainder. Every period start while dithering is off is therefore a sweep boundary. The first period after dithering stops keeps the setting of the sweep in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, about 7 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_sel | input | 1 | Rate request: 0 = divide 16, 1 = divide 8 |
| dith_en | input | 1 | Enables triangular period modulation |
| hop_en | input | 1 | Alternates the rate on every sweep boundary |
| tick | output | 1 | One-cycle pulse at the start of each period |
| period_clks | output | PER_W (5) | Length in clocks of the period just started |

## Verification
The bench builds the block with its default parameters: divides of 16 and 8, sweeps of 25 and 50 periods, four fractional bits and a one-eighth deviation. With these values the slow triangle steps in non-integer sixteenths (128k/25). This drives the remainder carry through every residue and makes the 400-clock sweep total a sharp test of it. A fast sweep of even length also reaches the zero crossing at mid-sweep. The sequence covers changes of the rate request in the middle of a sweep, hopping with a contradicting request, and dithering stopped part way through a sweep, where the kept setting and the forced phase reset are visible in the periods that follow.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
   typedef enum logic {
      RATE_SLOW = 1'b0,
      RATE_FAST = 1'b1
   } rate_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/dfs_tri_profile.sv
module dfs_tri_profile #(
   parameter int N   = 25,
   parameter int AMP = 32,
   parameter int KW  = 6,
   parameter int DW  = 10
) (
   input  logic [KW-1:0]        idx,
   output logic signed [DW-1:0] dev
);
   if (N < 4) begin : g_bad_n
      $error("dfs_tri_profile: sweep length must be at least 4");
   end

   always_comb begin
      int i4, t, mag;
      i4 = 4 * int'(idx);
      if (i4 <= N)          t = i4;
      else if (i4 <= 3 * N) t = 2 * N - i4;
      else                  t = i4 - 4 * N;
      mag = ((t < 0) ? -t : t) * AMP / N;
      dev = (t < 0) ? -DW'(mag) : DW'(mag);
   end
endmodule

// File: rtl/dfs_period_ctr.sv
module dfs_period_ctr #(
   parameter int LW     = 9,
   parameter int FRAC_W = 4,
   parameter int PER_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LW-1:0]     len_fx,
   input  logic              keep_frac,
   output logic              start,
   output logic              tick,
   output logic [PER_W-1:0]  period_clks
);
   localparam int WHOLE_W = LW - FRAC_W;

   if (PER_W < WHOLE_W) begin : g_bad_w
      $error("dfs_period_ctr: PER_W too narrow for the longest period");
   end

   logic [PER_W-1:0]   rem_q;
   logic [FRAC_W-1:0]  acc_q;
   logic [LW-1:0]      sum;
   logic [WHOLE_W-1:0] whole;

   assign start = (rem_q <= PER_W'(1));
   assign sum   = LW'(acc_q) + len_fx;
   assign whole = sum[LW-1:FRAC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q       <= '0;
         acc_q       <= '0;
         tick        <= 1'b0;
         period_clks <= '0;
      end else if (start) begin
         rem_q       <= PER_W'(whole);
         acc_q       <= keep_frac ? sum[FRAC_W-1:0] : '0;
         tick        <= 1'b1;
         period_clks <= PER_W'(whole);
      end else begin
         rem_q <= rem_q - PER_W'(1);
         tick  <= 1'b0;
      end
   end

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   a_r2_start_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && period_clks > PER_W'(1)) |-> !start);
endmodule

// File: rtl/dfs_dither_clk.sv
module dfs_dither_clk
   import dfs_pkg::*;
#(
   parameter int DIV_SLOW  = 16,
   parameter int DIV_FAST  = 8,
   parameter int CYC_SLOW  = 25,
   parameter int CYC_FAST  = 50,
   parameter int FRAC_W    = 4,
   parameter int DEV_SHIFT = 3,
   parameter int PER_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fast_sel,
   input  logic             dith_en,
   input  logic             hop_en,
   output logic             tick,
   output logic [PER_W-1:0] period_clks
);
   localparam int DIV_MAX = imax(DIV_SLOW, DIV_FAST);
   localparam int CYC_MAX = imax(CYC_SLOW, CYC_FAST);
   localparam int LW      = $clog2(DIV_MAX << (FRAC_W + 1));
   localparam int DW      = LW + 1;
   localparam int KW      = $clog2(CYC_MAX);
   localparam int SLOW_LO = DIV_SLOW - (DIV_SLOW >> DEV_SHIFT);
   localparam int SLOW_HI = DIV_SLOW + (DIV_SLOW >> DEV_SHIFT);
   localparam int FAST_LO = DIV_FAST - (DIV_FAST >> DEV_SHIFT);
   localparam int FAST_HI = DIV_FAST + (DIV_FAST >> DEV_SHIFT);

   if (DEV_SHIFT < 1) begin : g_bad_shift
      $error("dfs_dither_clk: deviation must be below half of nominal");
   end
   if ((DIV_SLOW % (1 << DEV_SHIFT)) != 0 || (DIV_FAST % (1 << DEV_SHIFT)) != 0) begin : g_bad_div
      $error("dfs_dither_clk: divides must be multiples of the deviation step");
   end
   if (FAST_LO < 2 || SLOW_LO < 2) begin : g_bad_min
      $error("dfs_dither_clk: shortest period must be at least 2 clocks");
   end
   if (PER_W < LW - FRAC_W) begin : g_bad_per
      $error("dfs_dither_clk: PER_W too narrow");
   end

   rate_e                 sel_act, sel_use;
   logic [KW-1:0]         phase_q, phase_nx, phase_last;
   logic                  start, boundary;
   logic signed [DW-1:0]  dev_set [2];
   logic signed [DW-1:0]  dev_use, base_s, len_s;
   logic [LW-1:0]         len_fx;

   for (genvar g = 0; g < 2; g++) begin : g_prof
      localparam int NPER = (g == 1) ? CYC_FAST : CYC_SLOW;
      localparam int NDIV = (g == 1) ? DIV_FAST : DIV_SLOW;
      dfs_tri_profile #(
         .N  (NPER),
         .AMP((NDIV << FRAC_W) >> DEV_SHIFT),
         .KW (KW),
         .DW (DW)
      ) u_prof (
         .idx(phase_q),
         .dev(dev_set[g])
      );
   end

   always_comb begin
      boundary = (phase_q == '0);
      if (!boundary)   sel_use = sel_act;
      else if (hop_en) sel_use = rate_e'(~sel_act);
      else             sel_use = rate_e'(fast_sel);

      base_s  = (sel_use == RATE_FAST) ? DW'(DIV_FAST << FRAC_W) : DW'(DIV_SLOW << FRAC_W);
      dev_use = dith_en ? dev_set[sel_use] : '0;
      len_s   = base_s + dev_use;
      len_fx  = len_s[LW-1:0];

      phase_last = (sel_use == RATE_FAST) ? KW'(CYC_FAST - 1) : KW'(CYC_SLOW - 1);
      if (!dith_en)                  phase_nx = '0;
      else if (phase_q == phase_last) phase_nx = '0;
      else                           phase_nx = phase_q + KW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_act <= RATE_SLOW;
         phase_q <= '0;
      end else if (start) begin
         sel_act <= sel_use;
         phase_q <= phase_nx;
      end
   end

   dfs_period_ctr #(
      .LW    (LW),
      .FRAC_W(FRAC_W),
      .PER_W (PER_W)
   ) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .len_fx     (len_fx),
      .keep_frac  (dith_en),
      .start      (start),
      .tick       (tick),
      .period_clks(period_clks)
   );

   a_r3_nominal_len: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !dith_en) |=> period_clks ==
         ((sel_act == RATE_FAST) ? PER_W'(DIV_FAST) : PER_W'(DIV_SLOW)));
   a_r4_slow_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel_act == RATE_SLOW) |->
         (period_clks >= PER_W'(SLOW_LO) && period_clks <= PER_W'(SLOW_HI)));
   a_r4_fast_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel_act == RATE_FAST) |->
         (period_clks >= PER_W'(FAST_LO) && period_clks <= PER_W'(FAST_HI)));
   a_r7_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != '0) |=> sel_act == $past(sel_act));
   a_r9_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !dith_en) |=> phase_q == '0);
endmodule

// File: tb/sim_dfs_dither_clk.sv
`timescale 1ns/1ps
module sim_dfs_dither_clk;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fast_sel = 1'b0;
   logic       dith_en = 1'b0;
   logic       hop_en = 1'b0;
   logic       tick;
   logic [4:0] period_clks;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   dfs_dither_clk u0 (
      .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .dith_en(dith_en),
      .hop_en(hop_en), .tick(tick), .period_clks(period_clks)
   );

   // behavioural reference
   int m_rem = 0, m_k = 0, m_acc = 0, m_sel = 0, m_per = 0;
   bit m_tick = 0, m_bnd = 0, m_dith = 0, m_valid = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rem = 0; m_k = 0; m_acc = 0; m_sel = 0; m_per = 0;
         m_tick = 0; m_bnd = 0; m_dith = 0; m_valid = 1;
      end else if (m_rem <= 1) begin
         int nom, n, t, dev, tot;
         m_bnd = (m_k == 0);
         if (m_bnd) m_sel = hop_en ? 1 - m_sel : int'(fast_sel);
         nom = m_sel ? 8 : 16;
         n   = m_sel ? 50 : 25;
         dev = 0;
         if (dith_en) begin
            if (4 * m_k <= n)          t = 4 * m_k;
            else if (4 * m_k <= 3 * n) t = 2 * n - 4 * m_k;
            else                       t = 4 * m_k - 4 * n;
            dev = (2 * nom * t) / n;
         end
         tot    = m_acc + nom * 16 + dev;
         m_per  = tot / 16;
         m_acc  = dith_en ? tot % 16 : 0;
         m_k    = dith_en ? (m_k + 1) % n : 0;
         m_dith = dith_en;
         m_rem  = m_per;
         m_tick = 1;
      end else begin
         m_rem  = m_rem - 1;
         m_tick = 0;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison, tick spacing and sweep totals
   int  gap = 0, last_per = 0, sweep = 0;
   bit  gap_ok = 0, sweep_ok = 0;
   always @(negedge clk) begin
      if (m_valid && rst_n) begin
         check(tick == m_tick, "R2 tick", int'(tick), int'(m_tick));
         check(int'(period_clks) == m_per, "R5/R6 period", int'(period_clks), m_per);
         gap++;
         sweep++;
         if (tick) begin
            if (gap_ok) check(gap == last_per, "R2 spacing", gap, last_per);
            gap = 0; gap_ok = 1; last_per = int'(period_clks);
            if (!m_dith) sweep_ok = 0;
            if (m_bnd) begin
               if (sweep_ok) check(sweep == 400, "R6 sweep total", sweep, 400);
               sweep = 0; sweep_ok = m_dith;
            end
         end
      end
   end

   task automatic next_tick();
      do @(negedge clk); while (!tick);
   endtask

   task automatic in_range(input int lo, input int hi, input string req);
      check(int'(period_clks) >= lo && int'(period_clks) <= hi, req,
            int'(period_clks), (period_clks < lo) ? lo : hi);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      bit varied;
      repeat (4) @(negedge clk);
      check(tick == 0, "R1 reset tick", int'(tick), 0);
      check(period_clks == 0, "R1 reset period", int'(period_clks), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(tick == 1, "R1 first tick", int'(tick), 1);
      check(period_clks == 16, "R3 slow nominal", int'(period_clks), 16);
      repeat (4) begin next_tick(); check(period_clks == 16, "R3 slow", int'(period_clks), 16); end
      fast_sel = 1'b1;
      next_tick(); check(period_clks == 8, "R9 boundary each period", int'(period_clks), 8);
      repeat (3) begin next_tick(); check(period_clks == 8, "R3 fast", int'(period_clks), 8); end

      // dithered slow sweep
      fast_sel = 1'b0; dith_en = 1'b1;
      varied = 0;
      repeat (25) begin
         next_tick(); in_range(14, 18, "R4 slow range");
         if (period_clks != 16) varied = 1;
      end
      check(varied, "R5 triangle active", int'(varied), 1);
      repeat (5) next_tick();
      fast_sel = 1'b1;   // mid-sweep request
      repeat (20) begin next_tick(); in_range(14, 18, "R7 held slow"); end
      next_tick(); in_range(7, 9, "R7 fast at boundary");
      repeat (49) begin next_tick(); in_range(7, 9, "R4 fast range"); end

      // hopping, with a contradicting request
      hop_en = 1'b1;
      next_tick(); in_range(14, 18, "R8 hop to slow");
      repeat (24) next_tick();
      next_tick(); in_range(7, 9, "R8 hop to fast");
      repeat (10) next_tick();

      // stop dithering mid-sweep
      hop_en = 1'b0; dith_en = 1'b0; fast_sel = 1'b0;
      next_tick(); check(period_clks == 8, "R9 setting kept", int'(period_clks), 8);
      next_tick(); check(period_clks == 16, "R9 phase reset", int'(period_clks), 16);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule